// File: doc/BRIEF.md
# Period-Measuring Up-Counter with Sticky Status Flags

This block is a 16-bit up-counter with two operating modes. It is driven from a small synchronous register bus. In timer mode the counter runs freely. It raises a match flag when it meets a programmable limit. In measurement mode, each rising edge of an input waveform does two things: it copies the running count into a capture register, and it restarts the count at zero. The captured value is then the period of that waveform, in count-enable pulses. A separate flag reports a period that is longer than the limit.

The count-enable pulse comes from one of two sources. It can be an internal divider that counts by 1, 2, 4, 8, 16, 32 or 64, or it can be edges of an external clock pin. For the external clock, software chooses whether rising or falling edges are counted. The overflow, limit-overflow and match flags are sticky. Software clears a flag by reading it as 1 and then writing 0 to its bit. A flag event that arrives in between cancels the pending clear.

Register map, word addresses on `bus_addr`:
- 0: status. Bit 7 is overflow, bit 6 is limit overflow, bit 5 is match, and bit 4 is the external-edge select.
- 1: control. Bit 3 is the mode (0 for timer, 1 for measurement), and bits 2:0 are the clock select.
- 2: counter.
- 3: limit.
- 4: capture, which is read-only.

Top module: `cyc_meas_timer`

## Requirements
- R1: After reset, status reads 0x00, control reads 0x0000, limit reads 0xFFFF and capture reads 0x0000.
- R2: With clock select 0 to 6 (control bits 2:0), the counter advances by one every 2^select system cycles, and never by more than one per cycle.
- R3: With clock select 7, the counter advances once per external clock edge. Status bit 4 picks the edge: 1 counts rising edges and 0 counts falling edges. Status bit 4 reads back what was written.
- R4: When a count-enable pulse moves the counter from 0xFFFF to 0x0000, status bit 7 is set.
- R5: In timer mode, status bit 5 is set when a count-enable pulse occurs while the counter equals the limit.
- R6: In measurement mode, a rising edge of `meas_in` copies the counter into capture and reloads the counter with 0. The captured value equals the number of count-enable pulses strictly between two successive edges.
- R7: In measurement mode, status bit 6 is set when the value being captured is greater than the limit. It stays 0 when the value is not greater.
- R8: In measurement mode, status bit 5 is never set, even when the counter equals the limit.
- R9: A flag bit clears only when a status read has returned it as 1 and the next status write carries 0 in that bit. Writing 1, or writing 0 without that earlier read, leaves the flag set. Any status write ends the pending clear.
- R10: A flag event after the arming read cancels the pending clear, so the flag survives the next write of 0. An event in the same cycle as that write also keeps the flag set.
- R11: A bus write to the counter loads it and takes precedence over counting and restart in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clears on status reads) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| ext_clk | input | 1 | External count clock, asynchronous |
| meas_in | input | 1 | Waveform to be measured, asynchronous |

## Verification
A register write takes effect at the first clock edge that sees the strobe. A flag appears one edge after the count-enable pulse that causes it. The two asynchronous inputs pass through two synchronizer stages and an edge register, so a level change made between edges acts at the third edge after it. The bench therefore separates waveform edges by exact numbers of cycles and expects a capture one less than each gap. It reads counts over windows that are whole multiples of the divide ratio, so the phase of the divider cannot change the difference. All reads sample the combinational read port one time step after a falling edge, well clear of any register update.

// File: rtl/cyc_meas_timer.sv
module cyc_meas_timer #(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          ext_clk,
  input  logic          meas_in
);
  localparam int PW = 6;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt, limit, cap;
  logic [PW-1:0] pre, pmask;
  logic [2:0]    cks, flags, arm, ev;
  logic          mode, esel;
  logic [2:0]    es, ms;

  wire st_wr  = bus_wr && bus_addr == AW'(0);
  wire st_rd  = bus_rd && bus_addr == AW'(0) && !st_wr;
  wire ctl_wr = bus_wr && bus_addr == AW'(1);
  wire cnt_ld = bus_wr && bus_addr == AW'(2);
  wire lim_wr = bus_wr && bus_addr == AW'(3);

  wire e_rise = es[1] & ~es[2];
  wire e_fall = ~es[1] & es[2];
  wire m_edge = ms[1] & ~ms[2];
  wire meas_rs = mode && m_edge;

  assign pmask = PW'((7'd1 << cks) - 7'd1);
  wire tick = (cks == 3'b111) ? (esel ? e_rise : e_fall) : ((pre & pmask) == pmask);

  assign ev[2] = tick && cnt == CMAX && !cnt_ld && !meas_rs;
  assign ev[1] = meas_rs && cnt > limit;
  assign ev[0] = !mode && tick && cnt == limit && !cnt_ld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      es <= '0;
      ms <= '0;
      pre <= '0;
    end else begin
      es <= {es[1:0], ext_clk};
      ms <= {ms[1:0], meas_in};
      pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      cap <= '0;
    end else begin
      if (meas_rs) cap <= cnt;
      if (cnt_ld) cnt <= bus_wdata;
      else if (meas_rs) cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit <= CMAX;
      mode <= 1'b0;
      cks <= 3'd0;
      esel <= 1'b0;
    end else begin
      if (lim_wr) limit <= bus_wdata;
      if (ctl_wr) begin
        mode <= bus_wdata[3];
        cks <= bus_wdata[2:0];
      end
      if (st_wr) esel <= bus_wdata[4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      arm <= '0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (ev[i]) begin
          flags[i] <= 1'b1;
          arm[i] <= 1'b0;
        end else if (st_wr) begin
          if (arm[i] && !bus_wdata[5+i]) flags[i] <= 1'b0;
          arm[i] <= 1'b0;
        end else if (st_rd) begin
          arm[i] <= flags[i];
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      AW'(0):  bus_rdata = CW'({flags, esel, 4'b0000});
      AW'(1):  bus_rdata = CW'({mode, cks});
      AW'(2):  bus_rdata = cnt;
      AW'(3):  bus_rdata = limit;
      AW'(4):  bus_rdata = cap;
      default: bus_rdata = '0;
    endcase
  end
endmodule

module cmt_checks #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_ld,
  input logic          meas_rs,
  input logic          st_wr,
  input logic          mode,
  input logic          tick,
  input logic [CW-1:0] wdata,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cap,
  input logic [CW-1:0] limit,
  input logic [2:0]    flags
);
  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == {CW{1'b1}} && !cnt_ld && !meas_rs) |=> flags[2]); // R4
  AST_NO_MATCH_IN_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !flags[0]) |=> !flags[0]); // R8
  AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && wdata[7] && flags[2]) |=> flags[2]); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !st_wr) |=> flags[1]); // R9
  AST_RESTART_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_rs && !cnt_ld) |=> (cnt == '0 && cap == $past(cnt))); // R6
  AST_LIMIT_EXCEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_rs && cnt > limit) |=> flags[1]); // R7
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_ld && !meas_rs) |=> (cnt == $past(cnt) || cnt == CW'($past(cnt) + 1'b1))); // R2
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ld |=> cnt == $past(wdata)); // R11
endmodule

bind cyc_meas_timer cmt_checks #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_ld(cnt_ld), .meas_rs(meas_rs), .st_wr(st_wr),
  .mode(mode), .tick(tick), .wdata(bus_wdata), .cnt(cnt), .cap(cap),
  .limit(limit), .flags(flags)
);

// File: tb/cyc_meas_timer_test.sv
module cyc_meas_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic ext_clk = 1'b0, meas_in = 1'b0;
  int tests = 0, fails = 0;
  bit done = 0;

  localparam logic [2:0] A_ST = 3'd0, A_CTL = 3'd1, A_CNT = 3'd2, A_LIM = 3'd3, A_CAP = 3'd4;

  cyc_meas_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk), .meas_in(meas_in)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic clear_all();
    logic [15:0] s;
    rd(A_ST, s);
    wr(A_ST, s & 16'h0010);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    peek(A_ST, v);  chk("R1 status", v, 16'h0000);
    peek(A_CTL, v); chk("R1 control", v, 16'h0000);
    peek(A_LIM, v); chk("R1 limit", v, 16'hFFFF);
    peek(A_CAP, v); chk("R1 capture", v, 16'h0000);
  endtask

  task automatic t_overflow();
    logic [15:0] v;
    wr(A_LIM, 16'h1000);
    wr(A_CNT, 16'hFFFD);
    repeat (6) @(negedge clk);
    peek(A_ST, v); chk("R4 overflow set", v, 16'h0080);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    wr(A_ST, 16'h0080);
    rd(A_ST, v); chk("R9 write 1 keeps flag", v, 16'h0080);
    wr(A_ST, 16'h0080);
    wr(A_ST, 16'h0000);
    rd(A_ST, v); chk("R9 unarmed write 0 keeps flag", v, 16'h0080);
    wr(A_ST, 16'h0000);
    peek(A_ST, v); chk("R9 read then write 0 clears", v, 16'h0000);
  endtask

  task automatic t_race();
    logic [15:0] v;
    wr(A_CNT, 16'hFFFD);
    repeat (6) @(negedge clk);
    rd(A_ST, v); chk("R10 armed read", v, 16'h0080);
    wr(A_CNT, 16'hFFFF);
    wr(A_ST, 16'h0000);
    peek(A_ST, v); chk("R10 event cancels clear", v, 16'h0080);
    clear_all();
    peek(A_ST, v); chk("R10 fresh clear", v, 16'h0000);
  endtask

  task automatic t_compare();
    logic [15:0] v;
    wr(A_LIM, 16'h0040);
    wr(A_CNT, 16'h0030);
    repeat (40) @(negedge clk);
    peek(A_ST, v); chk("R5 match in timer mode", v, 16'h0020);
    clear_all();
    peek(A_ST, v); chk("R5 match cleared", v, 16'h0000);
  endtask

  task automatic ratio(input logic [2:0] sel, input int win, input logic [15:0] exp);
    logic [15:0] c0, c1;
    wr(A_CTL, {13'd0, sel});
    @(negedge clk);
    peek(A_CNT, c0);
    repeat (win) @(negedge clk);
    peek(A_CNT, c1);
    chk($sformatf("R2 divide select %0d", sel), c1 - c0, exp);
  endtask

  task automatic t_prescale();
    ratio(3'd0, 10, 16'd10);
    ratio(3'd1, 16, 16'd8);
    ratio(3'd3, 64, 16'd8);
    ratio(3'd6, 128, 16'd2);
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk = 1'b1;
      repeat (3) @(negedge clk); ext_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_extclk();
    logic [15:0] v;
    wr(A_CTL, 16'h0007);
    wr(A_ST, 16'h0010);
    peek(A_ST, v); chk("R3 edge select readback", v, 16'h0010);
    wr(A_CNT, 16'h1234);
    repeat (3) @(negedge clk);
    peek(A_CNT, v); chk("R11 load holds", v, 16'h1234);
    ext_pulses(5);
    peek(A_CNT, v); chk("R3 rising edges", v, 16'h1239);
    wr(A_ST, 16'h0000);
    ext_pulses(4);
    peek(A_CNT, v); chk("R3 falling edges", v, 16'h123D);
  endtask

  task automatic rise_gap(input int gap);
    meas_in = 1'b1;
    repeat (3) @(negedge clk);
    meas_in = 1'b0;
    repeat (gap - 3) @(negedge clk);
  endtask

  task automatic t_measure();
    logic [15:0] v;
    wr(A_LIM, 16'h0100);
    wr(A_CTL, 16'h0008);
    @(negedge clk);
    rise_gap(10);
    clear_all();
    @(negedge clk);
    rise_gap(8);
    rise_gap(20);
    meas_in = 1'b1;
    repeat (3) @(negedge clk);
    meas_in = 1'b0;
    repeat (5) @(negedge clk);
    peek(A_CAP, v); chk("R6 captured period", v, 16'd19);
    peek(A_ST, v);  chk("R7 no flag below limit", v, 16'h0000);
    repeat (292) @(negedge clk);
    rise_gap(10);
    peek(A_CAP, v); chk("R6 long period", v, 16'd299);
    peek(A_ST, v);  chk("R7 R8 limit flag only", v, 16'h0040);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_overflow();
    t_clear();
    t_race();
    t_compare();
    t_prescale();
    t_extclk();
    t_measure();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule